// File: doc/BRIEF.md
# Debug Exit Resume Controller

The block runs the processor side of leaving halted debug mode when a go-and-exit command arrives. On the command strobe it captures a snapshot of the scan-loaded control/status state: the program counter, the instruction word, the PC-invalid flag, a 2-bit pipeline offset and the instruction-breakpoint status group. It then builds the values that normal execution resumes from.

When the offset is nonzero, the captured PC is moved back by that many 4-byte words, modulo 2^32. A no-operation word then takes the place of the captured instruction, and the breakpoint status bits are cleared. When the PC-invalid flag is set, the offset is ignored, and a recovery PC and instruction supplied beside the snapshot are used instead. This is the case where an exception vector fetch faulted.

If any breakpoint status bit is still set after this correction, the block signals an immediate return to debug mode and issues nothing. Otherwise it issues the restored instruction for one cycle. In the next cycle it requests a fetch at the restored PC plus 4, and then it goes back to the halted state.

Top module: `dbg_resume_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `halted_o` is 1 and `issue_valid_o`, `fetch_req_o` and `reenter_o` are 0.
- R2: `go_exit_i` is accepted only while `halted_o` is 1. A strobe at any other time has no effect on the running sequence and starts no later one. The snapshot inputs are sampled only in the accepting cycle.
- R3: With PC-invalid 0 and offset 0, the issued PC equals the captured PC and the issued instruction equals the captured instruction.
- R4: With PC-invalid 0 and offset k≠0, the issued PC is the captured PC minus 4·k modulo 2^32, and the issued instruction is 0x6000_0000.
- R5: With PC-invalid 1, the issued PC and instruction are `recov_pc_i` and `recov_ir_i`, whatever the offset.
- R6: `exit_stat_o` is the captured 6-bit status, except that bits 5..2 are forced to 0 when R4 applied. Bits 1..0 always pass unchanged.
- R7: If bits 5..2 of `exit_stat_o` are not all 0, `reenter_o` pulses for one cycle, beginning after the third rising edge counted from the accepting edge. `halted_o` is 1 in that cycle, and neither an issue nor a fetch occurs.
- R8: Otherwise `issue_valid_o` is high for exactly that one cycle. In the cycle after it, `fetch_req_o` is high for one cycle with `fetch_addr_o` equal to the issued PC plus 4, modulo 2^32.
- R9: After a fetch request, `halted_o` returns to 1 in the next cycle, and a new go-and-exit is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_exit_i | input | 1 | Go-and-exit command strobe |
| snap_pc_i | input | 32 | Captured program counter |
| snap_ir_i | input | 32 | Captured instruction word |
| snap_pcinv_i | input | 1 | PC-invalid flag from debug entry |
| snap_ofst_i | input | 2 | Pipeline offset in 4-byte words |
| snap_stat_i | input | 6 | Status group; bits 5..2 are instruction-breakpoint status |
| recov_pc_i | input | 32 | Recovery PC used when PC-invalid is set |
| recov_ir_i | input | 32 | Recovery instruction used when PC-invalid is set |
| halted_o | output | 1 | Core is held in debug mode and accepts a command |
| reenter_o | output | 1 | One-cycle pulse: debug mode re-entered without execution |
| issue_valid_o | output | 1 | One-cycle pulse issuing the restored instruction |
| issue_pc_o | output | 32 | Restored PC for the issued instruction |
| issue_ir_o | output | 32 | Restored instruction word |
| fetch_req_o | output | 1 | One-cycle fetch request after the issue |
| fetch_addr_o | output | 32 | Fetch address, restored PC plus 4 |
| exit_stat_o | output | 6 | Status group written back on exit |

## Verification
The assertions assume that reset is applied before the first strobe and that the snapshot inputs are meaningful only in the cycle a strobe is accepted. Apart from that, they expect nothing of the inputs. They hold even when strobes arrive back to back or in the middle of a sequence. The stimulus therefore drives random values on the snapshot buses in every cycle except the accepting one. It also sends extra strobes during the busy cycles, so the input-independence of the checked properties is exercised and not simply assumed. The random offsets, flags and status bits cover every branch between recovery, offset correction and plain restore. Directed cases cover PC wrap-around and the status bits that cannot block resumption.

// File: rtl/dbg_resume_pkg.sv
package dbg_resume_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_CHECK = 3'd2,
    ST_ISSUE = 3'd3,
    ST_FETCH = 3'd4
  } rsm_state_e;

  localparam logic [31:0] NOP_WORD_DEF = 32'h6000_0000;

endpackage

// File: rtl/resume_restore_dp.sv
module resume_restore_dp #(
  parameter int          XLEN       = 32,
  parameter int          OFST_W     = 2,
  parameter int          STAT_W     = 6,
  parameter int          BP_LO      = 2,
  parameter int          BP_HI      = 5,
  parameter int          INSN_SHIFT = 2,
  parameter logic [XLEN-1:0] NOP_WORD = 32'h6000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              corr_en,
  input  logic              fetch_en,
  input  logic [XLEN-1:0]   snap_pc,
  input  logic [XLEN-1:0]   snap_ir,
  input  logic              snap_pcinv,
  input  logic [OFST_W-1:0] snap_ofst,
  input  logic [STAT_W-1:0] snap_stat,
  input  logic [XLEN-1:0]   recov_pc,
  input  logic [XLEN-1:0]   recov_ir,
  output logic [XLEN-1:0]   out_pc,
  output logic [XLEN-1:0]   out_ir,
  output logic [STAT_W-1:0] out_stat,
  output logic [XLEN-1:0]   out_fetch_addr,
  output logic              out_adjusted
);

  localparam logic [XLEN-1:0] STEP = XLEN'(1) << INSN_SHIFT;

  logic [XLEN-1:0]   cap_pc, cap_ir, cap_rpc, cap_rir;
  logic              cap_pcinv;
  logic [OFST_W-1:0] cap_ofst;
  logic [STAT_W-1:0] cap_stat;

  logic              do_adjust;
  logic [XLEN-1:0]   back_off;
  logic [XLEN-1:0]   nxt_pc, nxt_ir;
  logic [STAT_W-1:0] nxt_stat;

  // Snapshot capture, only in the accepting cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_pc    <= '0;
      cap_ir    <= '0;
      cap_rpc   <= '0;
      cap_rir   <= '0;
      cap_pcinv <= 1'b0;
      cap_ofst  <= '0;
      cap_stat  <= '0;
    end else if (cap_en) begin
      cap_pc    <= snap_pc;
      cap_ir    <= snap_ir;
      cap_rpc   <= recov_pc;
      cap_rir   <= recov_ir;
      cap_pcinv <= snap_pcinv;
      cap_ofst  <= snap_ofst;
      cap_stat  <= snap_stat;
    end
  end

  assign do_adjust = !cap_pcinv && (cap_ofst != '0);
  assign back_off  = XLEN'(cap_ofst) << INSN_SHIFT;

  // Restore selection: recovery, offset correction or plain restore
  always_comb begin
    nxt_pc   = cap_pc;
    nxt_ir   = cap_ir;
    nxt_stat = cap_stat;
    if (cap_pcinv) begin
      nxt_pc = cap_rpc;
      nxt_ir = cap_rir;
    end else if (do_adjust) begin
      nxt_pc = cap_pc - back_off;
      nxt_ir = NOP_WORD;
      for (int b = BP_LO; b <= BP_HI; b++) nxt_stat[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_pc       <= '0;
      out_ir       <= '0;
      out_stat     <= '0;
      out_adjusted <= 1'b0;
    end else if (corr_en) begin
      out_pc       <= nxt_pc;
      out_ir       <= nxt_ir;
      out_stat     <= nxt_stat;
      out_adjusted <= do_adjust;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           out_fetch_addr <= '0;
    else if (fetch_en) out_fetch_addr <= out_pc + STEP;
  end

  // R6: an adjusted restore leaves no breakpoint status behind
  a_r6_adjust_clears: assert property (@(posedge clk) disable iff (rst)
    out_adjusted |-> (out_stat[BP_HI:BP_LO] == '0));

  // R4: an adjusted restore always carries the no-operation word
  a_r4_adjust_nop: assert property (@(posedge clk) disable iff (rst)
    out_adjusted |-> (out_ir == NOP_WORD));

endmodule

// File: rtl/resume_reentry_chk.sv
module resume_reentry_chk #(
  parameter int STAT_W = 6,
  parameter int BP_LO  = 2,
  parameter int BP_HI  = 5
) (
  input  logic [STAT_W-1:0] stat,
  output logic              need_reentry
);

  localparam int BP_N = BP_HI - BP_LO + 1;

  logic [BP_N-1:0] bp_bits;

  generate
    for (genvar g = 0; g < BP_N; g++) begin : g_bp
      assign bp_bits[g] = stat[BP_LO + g];
    end
  endgenerate

  assign need_reentry = |bp_bits;

endmodule

// File: rtl/resume_seq_fsm.sv
module resume_seq_fsm
  import dbg_resume_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic need_reentry,
  output logic cap_en,
  output logic corr_en,
  output logic fetch_en,
  output logic halted_q,
  output logic reenter_q,
  output logic issue_q,
  output logic fetch_q
);

  rsm_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (go_i) nxt = ST_LOAD;
      ST_LOAD:  nxt = ST_CHECK;
      ST_CHECK: nxt = need_reentry ? ST_IDLE : ST_ISSUE;
      ST_ISSUE: nxt = ST_FETCH;
      ST_FETCH: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign cap_en   = (state == ST_IDLE) && go_i;
  assign corr_en  = (state == ST_LOAD);
  assign fetch_en = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      halted_q  <= 1'b1;
      reenter_q <= 1'b0;
      issue_q   <= 1'b0;
      fetch_q   <= 1'b0;
    end else begin
      state     <= nxt;
      halted_q  <= (nxt == ST_IDLE);
      reenter_q <= (state == ST_CHECK) && need_reentry;
      issue_q   <= (nxt == ST_ISSUE);
      fetch_q   <= (nxt == ST_FETCH);
    end
  end

  // R2: a load phase starts only from the halted state with a strobe
  a_r2_load_from_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |-> ($past(state) == ST_IDLE && $past(go_i)));

  // R8: every issue is followed by exactly one fetch
  a_r8_fetch_follows_issue: assert property (@(posedge clk) disable iff (rst)
    issue_q |=> (fetch_q && !issue_q));

  // R9: halted again right after the fetch cycle
  a_r9_halt_after_fetch: assert property (@(posedge clk) disable iff (rst)
    fetch_q |=> halted_q);

  // R7: at most one of the resume outputs at a time; re-entry is halted
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reenter_q, issue_q, fetch_q}));

  a_r7_reenter_halted: assert property (@(posedge clk) disable iff (rst)
    reenter_q |-> (halted_q && !$past(reenter_q)));

endmodule

// File: rtl/dbg_resume_ctrl.sv
module dbg_resume_ctrl
  import dbg_resume_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int OFST_W     = 2,
  parameter int STAT_W     = 6,
  parameter int BP_LO      = 2,
  parameter int BP_HI      = 5,
  parameter int INSN_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_exit_i,
  input  logic [XLEN-1:0]   snap_pc_i,
  input  logic [XLEN-1:0]   snap_ir_i,
  input  logic              snap_pcinv_i,
  input  logic [OFST_W-1:0] snap_ofst_i,
  input  logic [STAT_W-1:0] snap_stat_i,
  input  logic [XLEN-1:0]   recov_pc_i,
  input  logic [XLEN-1:0]   recov_ir_i,
  output logic              halted_o,
  output logic              reenter_o,
  output logic              issue_valid_o,
  output logic [XLEN-1:0]   issue_pc_o,
  output logic [XLEN-1:0]   issue_ir_o,
  output logic              fetch_req_o,
  output logic [XLEN-1:0]   fetch_addr_o,
  output logic [STAT_W-1:0] exit_stat_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(1) << INSN_SHIFT;

  logic cap_en, corr_en, fetch_en, need_reentry, adjusted;

  resume_seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .go_i         (go_exit_i),
    .need_reentry (need_reentry),
    .cap_en       (cap_en),
    .corr_en      (corr_en),
    .fetch_en     (fetch_en),
    .halted_q     (halted_o),
    .reenter_q    (reenter_o),
    .issue_q      (issue_valid_o),
    .fetch_q      (fetch_req_o)
  );

  resume_restore_dp #(
    .XLEN       (XLEN),
    .OFST_W     (OFST_W),
    .STAT_W     (STAT_W),
    .BP_LO      (BP_LO),
    .BP_HI      (BP_HI),
    .INSN_SHIFT (INSN_SHIFT),
    .NOP_WORD   (XLEN'(NOP_WORD_DEF))
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .cap_en         (cap_en),
    .corr_en        (corr_en),
    .fetch_en       (fetch_en),
    .snap_pc        (snap_pc_i),
    .snap_ir        (snap_ir_i),
    .snap_pcinv     (snap_pcinv_i),
    .snap_ofst      (snap_ofst_i),
    .snap_stat      (snap_stat_i),
    .recov_pc       (recov_pc_i),
    .recov_ir       (recov_ir_i),
    .out_pc         (issue_pc_o),
    .out_ir         (issue_ir_o),
    .out_stat       (exit_stat_o),
    .out_fetch_addr (fetch_addr_o),
    .out_adjusted   (adjusted)
  );

  resume_reentry_chk #(
    .STAT_W (STAT_W),
    .BP_LO  (BP_LO),
    .BP_HI  (BP_HI)
  ) u_chk (
    .stat         (exit_stat_o),
    .need_reentry (need_reentry)
  );

  // R8: fetch address is the issued PC plus one instruction
  a_r8_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    fetch_req_o |-> (fetch_addr_o == issue_pc_o + STEP));

  // R7: re-entry is only signalled with breakpoint status still pending
  a_r7_reenter_cause: assert property (@(posedge clk) disable iff (rst)
    reenter_o |-> (exit_stat_o[BP_HI:BP_LO] != '0));

  // R6: an adjusted exit never re-enters
  a_r6_adjusted_no_reenter: assert property (@(posedge clk) disable iff (rst)
    adjusted |-> !reenter_o);

endmodule

// File: tb/dbg_resume_ctrl_tb.sv
module dbg_resume_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        go_exit_i;
  logic [31:0] snap_pc_i, snap_ir_i, recov_pc_i, recov_ir_i;
  logic        snap_pcinv_i;
  logic [1:0]  snap_ofst_i;
  logic [5:0]  snap_stat_i;
  logic        halted_o, reenter_o, issue_valid_o, fetch_req_o;
  logic [31:0] issue_pc_o, issue_ir_o, fetch_addr_o;
  logic [5:0]  exit_stat_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dbg_resume_ctrl u_dut (
    .clk(clk), .rst(rst), .go_exit_i(go_exit_i),
    .snap_pc_i(snap_pc_i), .snap_ir_i(snap_ir_i), .snap_pcinv_i(snap_pcinv_i),
    .snap_ofst_i(snap_ofst_i), .snap_stat_i(snap_stat_i),
    .recov_pc_i(recov_pc_i), .recov_ir_i(recov_ir_i),
    .halted_o(halted_o), .reenter_o(reenter_o), .issue_valid_o(issue_valid_o),
    .issue_pc_o(issue_pc_o), .issue_ir_o(issue_ir_o), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .exit_stat_o(exit_stat_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pc(logic [31:0] pc, logic inv, logic [1:0] of, logic [31:0] rpc);
    if (inv) return rpc;
    return pc - {28'd0, of, 2'b00};
  endfunction

  function automatic logic [31:0] exp_ir(logic [31:0] ir, logic inv, logic [1:0] of, logic [31:0] rir);
    if (inv) return rir;
    if (of != 2'd0) return 32'h6000_0000;
    return ir;
  endfunction

  function automatic logic [5:0] exp_stat(logic [5:0] st, logic inv, logic [1:0] of);
    if (!inv && of != 2'd0) return {4'b0000, st[1:0]};
    return st;
  endfunction

  task automatic scramble();
    snap_pc_i    = $urandom;
    snap_ir_i    = $urandom;
    snap_pcinv_i = 1'($urandom);
    snap_ofst_i  = 2'($urandom);
    snap_stat_i  = 6'($urandom);
    recov_pc_i   = $urandom;
    recov_ir_i   = $urandom;
  endtask

  // One go-and-exit sequence; busy_go adds strobes while running (R2)
  task automatic run_exit(input logic [31:0] pc, input logic [31:0] ir, input logic inv,
                          input logic [1:0] of, input logic [5:0] st,
                          input logic [31:0] rpc, input logic [31:0] rir, input bit busy_go);
    logic [31:0] epc, eir;
    logic [5:0]  est;
    bit          ere;
    epc = exp_pc(pc, inv, of, rpc);
    eir = exp_ir(ir, inv, of, rir);
    est = exp_stat(st, inv, of);
    ere = (est[5:2] != 4'd0);
    @(negedge clk);
    chk(halted_o == 1'b1, "R9 ready", 32'(halted_o), 32'd1);
    go_exit_i = 1'b1;
    snap_pc_i = pc; snap_ir_i = ir; snap_pcinv_i = inv; snap_ofst_i = of;
    snap_stat_i = st; recov_pc_i = rpc; recov_ir_i = rir;
    @(negedge clk);             // after accepting edge
    go_exit_i = busy_go;
    scramble();
    @(negedge clk);             // after edge 2
    go_exit_i = busy_go;
    scramble();
    @(negedge clk);             // after edge 3
    go_exit_i = 1'b0;
    chk(reenter_o == ere, "R7 reenter", 32'(reenter_o), 32'(ere));
    chk(issue_valid_o == !ere, "R8 issue", 32'(issue_valid_o), 32'(!ere));
    chk(exit_stat_o == est, "R6 status", 32'(exit_stat_o), 32'(est));
    if (ere) begin
      chk(halted_o == 1'b1, "R7 halted", 32'(halted_o), 32'd1);
      @(negedge clk);
      chk(!reenter_o && !issue_valid_o && !fetch_req_o, "R7 no execution",
          32'({reenter_o, issue_valid_o, fetch_req_o}), 32'd0);
    end else begin
      chk(issue_pc_o == epc, inv ? "R5 pc" : (of != 0 ? "R4 pc" : "R3 pc"), issue_pc_o, epc);
      chk(issue_ir_o == eir, inv ? "R5 ir" : (of != 0 ? "R4 ir" : "R3 ir"), issue_ir_o, eir);
      @(negedge clk);           // after edge 4
      chk(fetch_req_o && !issue_valid_o, "R8 fetch", 32'({fetch_req_o, issue_valid_o}), 32'd2);
      chk(fetch_addr_o == epc + 32'd4, "R8 fetch addr", fetch_addr_o, epc + 32'd4);
      @(negedge clk);           // after edge 5
      chk(halted_o && !fetch_req_o, "R9 halted", 32'({halted_o, fetch_req_o}), 32'd2);
    end
    if (busy_go) begin
      repeat (4) begin
        @(negedge clk);
        chk(!issue_valid_o && !reenter_o && !fetch_req_o, "R2 busy strobe ignored",
            32'({issue_valid_o, reenter_o, fetch_req_o}), 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    rst = 1'b1; go_exit_i = 1'b0;
    scramble();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(halted_o && !issue_valid_o && !fetch_req_o && !reenter_o, "R1 reset",
        32'({halted_o, issue_valid_o, fetch_req_o, reenter_o}), 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(halted_o && !issue_valid_o && !fetch_req_o && !reenter_o, "R1 after reset",
        32'({halted_o, issue_valid_o, fetch_req_o, reenter_o}), 32'h8);

    // Directed corners
    run_exit(32'h0000_1000, 32'h1234_5678, 1'b0, 2'd0, 6'b000011, 32'h0, 32'h0, 1'b0); // R3
    run_exit(32'h0000_1000, 32'h1234_5678, 1'b0, 2'd3, 6'b111100, 32'h0, 32'h0, 1'b0); // R4 R6
    run_exit(32'h0000_0004, 32'hAAAA_5555, 1'b0, 2'd2, 6'b000000, 32'h0, 32'h0, 1'b0); // R4 wrap
    run_exit(32'hFFFF_FFFC, 32'h0BAD_F00D, 1'b0, 2'd0, 6'b000000, 32'h0, 32'h0, 1'b0); // R8 wrap
    run_exit(32'h4000_0000, 32'h1111_1111, 1'b1, 2'd3, 6'b000010, 32'h8000_0100, 32'h2222_2222, 1'b0); // R5
    run_exit(32'h4000_0000, 32'h1111_1111, 1'b0, 2'd0, 6'b000100, 32'h0, 32'h0, 1'b1); // R7 R2
    run_exit(32'h4000_0000, 32'h1111_1111, 1'b1, 2'd1, 6'b100000, 32'h5, 32'h6, 1'b0); // R7 R5
    run_exit(32'h0000_2000, 32'h3333_3333, 1'b0, 2'd1, 6'b000001, 32'h0, 32'h0, 1'b1); // R2

    for (int i = 0; i < 300; i++) begin
      run_exit($urandom, $urandom, 1'($urandom), 2'($urandom),
               ($urandom % 2) ? 6'($urandom) : 6'($urandom) & 6'b000011,
               $urandom, $urandom, 1'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule